// File: doc/BRIEF.md
# Exception Priority Vector Selector

This block sits beside a small processor core and resolves its pending exception requests. Seven request lines come in: hardware reset, data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt and undefined instruction. Two mask inputs can hold back the two interrupt lines. On every clock edge the block picks the single most urgent unmasked request. It registers a one-hot grant, the address of that exception's vector and the 5-bit processor mode the core must enter.

The vector table spans 0x00 to 0x1C in steps of four. The slot at 0x14 belongs to no exception, so the block never emits it. When nothing unmasked is pending, the valid strobe drops, the grant is zero, and the vector and mode outputs keep their last values. The core can therefore go on reading them.

Top module: `exc_vector_sel`

## Requirements
- R1: After `rst_n` is released, and before any request, `sel_valid` is 0, `sel_grant` is 0, `sel_vector` is 0x00 and `sel_mode` is 5'b10011.
- R2: Priority from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, and then software interrupt and undefined instruction at the lowest level. Only the most urgent unmasked request is granted. `sel_grant` bit positions are 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 software interrupt, 6 undefined instruction. The grant is at most one-hot, and `sel_valid` is 1 exactly when one bit is set.
- R3: The vector addresses are: reset 0x00, undefined instruction 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R4: The mode codes are: 10011 for reset and software interrupt, 10111 for either abort, 11011 for undefined instruction, 10010 for the normal interrupt and 10001 for the fast interrupt.
- R5: `sel_vector` never takes the value 0x14.
- R6: When both are pending and unmasked, the fast interrupt wins over the normal interrupt.
- R7: `mask_fiq`=1 blocks the fast interrupt and `mask_irq`=1 blocks the normal interrupt. The masks have no effect on the other five sources.
- R8: When no unmasked request is pending, `sel_valid` is 0 and `sel_grant` is 0, while `sel_vector` and `sel_mode` hold their previous values.
- R9: Requests sampled at a rising clock edge appear on the outputs right after that same edge, and not before it.
- R10: Software interrupt and undefined instruction are never requested together. The bound checker flags a violation if they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_reset | input | 1 | Hardware reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| req_und | input | 1 | Undefined instruction request |
| mask_fiq | input | 1 | 1 blocks the fast interrupt |
| mask_irq | input | 1 | 1 blocks the normal interrupt |
| sel_valid | output | 1 | An exception was selected this cycle |
| sel_vector | output | 8 | Vector address of the selected exception |
| sel_mode | output | 5 | Mode code of the selected exception |
| sel_grant | output | 7 | One-hot grant, bit order as in R2 |

## Verification
The hardest case to reach is the hold behaviour. An idle cycle must leave the vector and mode of the most recent winner untouched, and that includes a cycle in which the only requests present are masked interrupts. The stimulus first lets a low-priority source win, so the held values differ from the reset values. It then either drops all requests or raises a masked interrupt, and confirms that the old vector and mode survive. Every pair of sources, except the forbidden software interrupt plus undefined instruction pair, is also driven together, so that each priority comparison is exercised.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSRC   = 7;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 5;

  typedef enum int {
    SRC_RST  = 0,
    SRC_DABT = 1,
    SRC_FIQ  = 2,
    SRC_IRQ  = 3,
    SRC_PABT = 4,
    SRC_SWI  = 5,
    SRC_UND  = 6
  } src_e;

  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;

  // vector slot index (address / 4); slot 5 is left unused
  function automatic logic [VEC_W-1:0] vec_of(input int src);
    logic [2:0] slot;
    case (src)
      SRC_RST:  slot = 3'd0;
      SRC_UND:  slot = 3'd1;
      SRC_SWI:  slot = 3'd2;
      SRC_PABT: slot = 3'd3;
      SRC_DABT: slot = 3'd4;
      SRC_IRQ:  slot = 3'd6;
      default:  slot = 3'd7;
    endcase
    return VEC_W'({slot, 2'b00});
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(input int src);
    case (src)
      SRC_RST, SRC_SWI:   return MODE_SVC;
      SRC_DABT, SRC_PABT: return MODE_ABT;
      SRC_UND:            return MODE_UND;
      SRC_IRQ:            return MODE_IRQ;
      default:            return MODE_FIQ;
    endcase
  endfunction
endpackage

// File: rtl/exc_req_gate.sv
module exc_req_gate
  import exc_pkg::*;
(
  input  logic [NSRC-1:0] raw_req,
  input  logic            mask_fiq,
  input  logic            mask_irq,
  output logic [NSRC-1:0] live_req
);
  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    if (i == SRC_FIQ) begin : g_f
      assign live_req[i] = raw_req[i] & ~mask_fiq;
    end else if (i == SRC_IRQ) begin : g_i
      assign live_req[i] = raw_req[i] & ~mask_irq;
    end else begin : g_p
      assign live_req[i] = raw_req[i];
    end
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] live_req,
  output logic [N-1:0] grant,
  output logic         any
);
  // seen[i]: some request with index below i (more urgent) is live
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant[i]  = live_req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | live_req[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/exc_vec_enc.sv
module exc_vec_enc
  import exc_pkg::*;
(
  input  logic [NSRC-1:0]   grant,
  output logic [VEC_W-1:0]  vec,
  output logic [MODE_W-1:0] mode
);
  always_comb begin
    vec  = '0;
    mode = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) begin
        vec  = vec  | vec_of(i);
        mode = mode | mode_of(i);
      end
    end
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_swi,
  input  logic              req_und,
  input  logic              mask_fiq,
  input  logic              mask_irq,
  output logic              sel_valid,
  output logic [VEC_W-1:0]  sel_vector,
  output logic [MODE_W-1:0] sel_mode,
  output logic [NSRC-1:0]   sel_grant
);
  logic [NSRC-1:0]   raw_req;
  logic [NSRC-1:0]   live_req;
  logic [NSRC-1:0]   pick_grant;
  logic              pick_any;
  logic [VEC_W-1:0]  pick_vec;
  logic [MODE_W-1:0] pick_mode;

  assign raw_req = {req_und, req_swi, req_pabt, req_irq, req_fiq, req_dabt, req_reset};

  exc_req_gate u_gate (
    .raw_req (raw_req),
    .mask_fiq(mask_fiq),
    .mask_irq(mask_irq),
    .live_req(live_req)
  );

  exc_prio_pick #(.N(NSRC)) u_pick (
    .live_req(live_req),
    .grant   (pick_grant),
    .any     (pick_any)
  );

  exc_vec_enc u_enc (
    .grant(pick_grant),
    .vec  (pick_vec),
    .mode (pick_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_grant  <= '0;
      sel_vector <= '0;
      sel_mode   <= MODE_SVC;
    end else begin
      sel_valid <= pick_any;
      sel_grant <= pick_grant;
      if (pick_any) begin
        sel_vector <= pick_vec;
        sel_mode   <= pick_mode;
      end
    end
  end
endmodule

// File: rtl/exc_vector_sel_chk.sv
module exc_vector_sel_chk
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_reset,
  input logic              req_fiq,
  input logic              req_irq,
  input logic              req_swi,
  input logic              req_und,
  input logic              mask_fiq,
  input logic              mask_irq,
  input logic              pick_any,
  input logic              sel_valid,
  input logic [VEC_W-1:0]  sel_vector,
  input logic [MODE_W-1:0] sel_mode,
  input logic [NSRC-1:0]   sel_grant
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_grant) && (sel_valid == ($countones(sel_grant) == 1)));

  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_reset |=> sel_grant[SRC_RST]);

  assert_fiq_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_grant[SRC_FIQ] |-> (sel_vector == 8'h1C));

  assert_und_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_grant[SRC_UND] |-> (sel_mode == 5'b11011));

  assert_no_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vector != 8'h14);

  assert_fiq_over_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fiq && !mask_fiq) |=> !sel_grant[SRC_IRQ]);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_irq |=> !sel_grant[SRC_IRQ]);

  assert_fiq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_fiq |=> !sel_grant[SRC_FIQ]);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_any |=> (!sel_valid && $stable(sel_vector) && $stable(sel_mode)));

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |=> sel_valid);

  assert_swi_und_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_swi && req_und));
endmodule

bind exc_vector_sel exc_vector_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_reset (req_reset),
  .req_fiq   (req_fiq),
  .req_irq   (req_irq),
  .req_swi   (req_swi),
  .req_und   (req_und),
  .mask_fiq  (mask_fiq),
  .mask_irq  (mask_irq),
  .pick_any  (pick_any),
  .sel_valid (sel_valid),
  .sel_vector(sel_vector),
  .sel_mode  (sel_mode),
  .sel_grant (sel_grant)
);

// File: tb/sim_exc_vector_sel.sv
`timescale 1ns/1ps
module sim_exc_vector_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] req = '0;   // {und, swi, pabt, irq, fiq, dabt, reset}
  logic mfiq = 1'b0, mirq = 1'b0;
  logic sel_valid;
  logic [7:0] sel_vector;
  logic [4:0] sel_mode;
  logic [6:0] sel_grant;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_vector_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req[0]), .req_dabt(req[1]), .req_fiq(req[2]), .req_irq(req[3]),
    .req_pabt(req[4]), .req_swi(req[5]), .req_und(req[6]),
    .mask_fiq(mfiq), .mask_irq(mirq),
    .sel_valid(sel_valid), .sel_vector(sel_vector),
    .sel_mode(sel_mode), .sel_grant(sel_grant)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // winner by name, most urgent first; -1 when none
  function automatic int model_win(input logic [6:0] r, input logic mf, input logic mi);
    if (r[0]) return 0;
    if (r[1]) return 1;
    if (r[2] && !mf) return 2;
    if (r[3] && !mi) return 3;
    if (r[4]) return 4;
    if (r[5]) return 5;
    if (r[6]) return 6;
    return -1;
  endfunction

  function automatic logic [7:0] model_vec(input int w);
    case (w)
      0: return 8'h00; 1: return 8'h10; 2: return 8'h1C; 3: return 8'h18;
      4: return 8'h0C; 5: return 8'h08; default: return 8'h04;
    endcase
  endfunction

  function automatic logic [4:0] model_mode(input int w);
    case (w)
      0, 5: return 5'b10011; 1, 4: return 5'b10111; 2: return 5'b10001;
      3: return 5'b10010; default: return 5'b11011;
    endcase
  endfunction

  task automatic apply(input logic [6:0] r, input logic mf, input logic mi);
    @(negedge clk);
    req = r; mfiq = mf; mirq = mi;
    @(negedge clk);
  endtask

  task automatic expect_win(input string rq, input logic [6:0] r, input logic mf, input logic mi);
    int w;
    apply(r, mf, mi);
    w = model_win(r, mf, mi);
    chk({rq, " valid"}, 32'(sel_valid), 32'(w >= 0));
    chk({rq, " grant"}, 32'(sel_grant), (w >= 0) ? (32'd1 << w) : 32'd0);
    if (w >= 0) begin
      chk({rq, " vector"}, 32'(sel_vector), 32'(model_vec(w)));
      chk({rq, " mode"}, 32'(sel_mode), 32'(model_mode(w)));
    end
    chk("R5 no 0x14", 32'(sel_vector == 8'h14), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(sel_valid), 32'd0);
    chk("R1 grant", 32'(sel_grant), 32'd0);
    chk("R1 vector", 32'(sel_vector), 32'h00);
    chk("R1 mode", 32'(sel_mode), 32'b10011);
  endtask

  task automatic t_singles();
    for (int i = 0; i < 7; i++) expect_win("R3 R4 single", 7'(1 << i), 1'b0, 1'b0);
  endtask

  task automatic t_pairs();
    for (int i = 0; i < 7; i++)
      for (int j = i + 1; j < 7; j++)
        if (!(i == 5 && j == 6)) expect_win("R2 pair", 7'((1 << i) | (1 << j)), 1'b0, 1'b0);
    expect_win("R2 all but und", 7'b0111111, 1'b0, 1'b0);
    expect_win("R6 fiq beats irq", 7'b0001100, 1'b0, 1'b0);
  endtask

  task automatic t_masks();
    expect_win("R7 fiq masked irq wins", 7'b0001100, 1'b1, 1'b0);
    expect_win("R7 irq masked pabt wins", 7'b0011000, 1'b0, 1'b1);
    expect_win("R7 masks ignore dabt", 7'b0001110, 1'b1, 1'b1);
    expect_win("R7 masks ignore und", 7'b1001100, 1'b1, 1'b1);
  endtask

  task automatic t_hold();
    expect_win("R8 set und", 7'b1000000, 1'b0, 1'b0);
    apply(7'b0, 1'b0, 1'b0);
    chk("R8 idle valid", 32'(sel_valid), 32'd0);
    chk("R8 idle grant", 32'(sel_grant), 32'd0);
    chk("R8 idle vector", 32'(sel_vector), 32'h04);
    chk("R8 idle mode", 32'(sel_mode), 32'b11011);
    expect_win("R8 set pabt", 7'b0010000, 1'b0, 1'b0);
    apply(7'b0001100, 1'b1, 1'b1);
    chk("R8 masked-only valid", 32'(sel_valid), 32'd0);
    chk("R8 masked-only vector", 32'(sel_vector), 32'h0C);
    chk("R8 masked-only mode", 32'(sel_mode), 32'b10111);
    apply(7'b0, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    req = 7'b0000100; mfiq = 1'b0; mirq = 1'b0;
    #1;
    chk("R9 before edge valid", 32'(sel_valid), 32'd0);
    @(posedge clk);
    #1;
    chk("R9 after edge valid", 32'(sel_valid), 32'd1);
    chk("R9 after edge vector", 32'(sel_vector), 32'h1C);
    @(negedge clk);
    req = 7'b0;
    #1;
    chk("R9 drop before edge", 32'(sel_valid), 32'd1);
    @(posedge clk);
    #1;
    chk("R9 drop after edge", 32'(sel_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_singles();
    t_pairs();      // R10: the swi+und pair is never driven
    t_masks();
    t_hold();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule